// File: doc/BRIEF.md
# Per-Area External Bus Controller

This block sits between an internal bus master and a simple asynchronous external memory bus. The external address space is split into eight equal areas. The top address bits pick the area, and each area drives its own active-low chip select. A small configuration port sets three things for each area: the external data width (8 or 16 bits), the basic access length (2 or 3 states), and a wait count. The controller then runs the external strobes for each access, one clock per state, and returns the read data with a single ready pulse.

A requester starts an access with a one-cycle (or longer) start strobe. The strobe carries the address, the direction and the size. The size is byte or 16-bit word. The block keeps the area's settings at the moment it accepts the request, so a later reconfiguration does not disturb an access that is already running. A word access to an 8-bit area becomes two back-to-back byte cycles. The controller merges the two bytes before it raises ready.

Top module: `ext_area_bus_ctl`

## Requirements
- R1: The area index is `req_addr[23:21]`. Only `ext_cs_n[area]` is low, and only during the external states of an access. All chip selects are high while idle and in the ready cycle.
- R2: After reset every area is set to 16-bit width, 3-state access and 3 wait states, so a word read takes 6 external states.
- R3: A write with `cfg_we` high stores `cfg_wide` (1 = 16-bit, 0 = 8-bit), `cfg_three` (1 = 3-state, 0 = 2-state) and `cfg_wait` for area `cfg_area` on that clock edge.
- R4: A 2-state byte cycle lasts 2 clocks, and its strobe is low for both of them.
- R5: A 3-state byte cycle lasts 3 + wait clocks. Its strobe is high in the first state and low from the second state to the last. `ext_rd_n` is the strobe for reads and `ext_wr_n` is the strobe for writes.
- R6: The wait field has no effect on a 2-state area.
- R7: A word access to an 8-bit area runs two byte cycles back to back. The first cycle uses the even address (bit 0 = 0) and the second uses the odd address. A word access to a 16-bit area runs once at the even address. A byte access drives `req_addr` unchanged.
- R8: Read data is sampled on the last clock of each byte cycle. The rules are:
  - A 16-bit area returns the full bus on a word read.
  - On a byte read of a 16-bit area, an even address takes the upper lane `ext_din[15:8]` and an odd address takes `ext_din[7:0]`.
  - An 8-bit area always uses `ext_din[7:0]`.
  - A split word puts the first byte in `rdata[15:8]`.
  - A byte result is zero-extended.
- R9: A word write to a 16-bit area drives `req_wdata` on `ext_dout`. Every other write cycle drives its byte on both lanes. That byte is `req_wdata[7:0]` for a byte write. For a split word it is the upper byte first and then the lower byte.
- R10: `busy` goes high on the clock after an accepted start and stays high through the single-cycle `rdy` pulse. Start strobes while `busy` is high are ignored.
- R11: An access uses the area settings sampled when it was accepted. A configuration write during the access does not change its timing, and consecutive accesses to different areas follow their own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_area | input | 3 | Area being configured |
| cfg_wide | input | 1 | 1 = 16-bit area, 0 = 8-bit area |
| cfg_three | input | 1 | 1 = 3-state access, 0 = 2-state access |
| cfg_wait | input | 2 | Wait states for a 3-state area |
| req_start | input | 1 | Access start strobe |
| req_addr | input | 24 | Access byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with rdy |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 8 | Per-area chip selects, active low |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
The assertions assume that the external read bus settles combinationally from the address. They also assume that no request appears while reset is active. The bench meets both conditions: its memory model computes `ext_din` directly from `ext_addr`, and it drives every input on the falling edge only after reset is released. The bench also holds start strobes high across busy periods and writes configuration in the middle of accesses. Both are legal stimulus that the design must tolerate, so the properties must hold under it.

// File: rtl/ext_area_bus_ctl.sv
module ext_area_bus_ctl #(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int NAREA = 8,
  parameter int WAITW = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NAREA)-1:0] cfg_area,
  input  logic                     cfg_wide,
  input  logic                     cfg_three,
  input  logic [WAITW-1:0]         cfg_wait,
  input  logic                     req_start,
  input  logic [AW-1:0]            req_addr,
  input  logic                     req_write,
  input  logic                     req_word,
  input  logic [DW-1:0]            req_wdata,
  output logic                     busy,
  output logic                     rdy,
  output logic [DW-1:0]            rdata,
  output logic [AW-1:0]            ext_addr,
  output logic [NAREA-1:0]         ext_cs_n,
  output logic                     ext_rd_n,
  output logic                     ext_wr_n,
  output logic [DW-1:0]            ext_dout,
  input  logic [DW-1:0]            ext_din
);
  localparam int AREA_W = $clog2(NAREA);
  localparam int BW     = DW / 2;
  localparam int MAXLEN = (1 << WAITW) + 2;
  localparam int CW     = $clog2(MAXLEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  logic [NAREA-1:0] wide_r, three_r;
  logic [WAITW-1:0] wait_r [NAREA];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_r  <= '1;
      three_r <= '1;
      for (int i = 0; i < NAREA; i++) wait_r[i] <= '1;
    end else if (cfg_we) begin
      wide_r[cfg_area]  <= cfg_wide;
      three_r[cfg_area] <= cfg_three;
      wait_r[cfg_area]  <= cfg_wait;
    end
  end

  st_t             st_q;
  logic [AW-1:0]   a_q;
  logic [DW-1:0]   wd_q;
  logic            wr_q, word_q, wide_a, three_a, half_q;
  logic [WAITW-1:0] wt_a;
  logic [CW-1:0]   ph_q;

  wire [AREA_W-1:0] req_area = req_addr[AW-1 -: AREA_W];
  wire [AREA_W-1:0] cur_area = a_q[AW-1 -: AREA_W];
  wire [CW-1:0]     last_ph  = three_a ? CW'(2) + CW'(wt_a) : CW'(1);
  wire              split    = word_q && !wide_a;
  wire              run      = (st_q == S_RUN);
  wire              strobe   = run && (!three_a || ph_q != '0);

  wire [BW-1:0] lo_in = ext_din[BW-1:0];
  wire [BW-1:0] hi_in = ext_din[DW-1:BW];
  wire [BW-1:0] rbyte = (!wide_a || a_q[0]) ? lo_in : hi_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      a_q     <= '0;
      wd_q    <= '0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      wide_a  <= 1'b1;
      three_a <= 1'b1;
      wt_a    <= '0;
      half_q  <= 1'b0;
      ph_q    <= '0;
      rdata   <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (req_start) begin
          a_q     <= req_addr;
          wd_q    <= req_wdata;
          wr_q    <= req_write;
          word_q  <= req_word;
          wide_a  <= wide_r[req_area];
          three_a <= three_r[req_area];
          wt_a    <= wait_r[req_area];
          half_q  <= 1'b0;
          ph_q    <= '0;
          st_q    <= S_RUN;
        end
        S_RUN: if (ph_q == last_ph) begin
          if (!wr_q) begin
            if (word_q && wide_a)  rdata <= ext_din;
            else if (split) begin
              if (!half_q) rdata[DW-1:BW] <= lo_in;
              else         rdata[BW-1:0]  <= lo_in;
            end else       rdata <= {{BW{1'b0}}, rbyte};
          end
          if (split && !half_q) begin
            half_q <= 1'b1;
            ph_q   <= '0;
          end else begin
            st_q <= S_DONE;
          end
        end else begin
          ph_q <= ph_q + CW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign rdy      = (st_q == S_DONE);
  assign ext_rd_n = !(strobe && !wr_q);
  assign ext_wr_n = !(strobe && wr_q);
  assign ext_addr = {a_q[AW-1:1], word_q ? (!wide_a && half_q) : a_q[0]};

  wire [BW-1:0] wbyte = !word_q ? wd_q[BW-1:0] :
                        (half_q ? wd_q[BW-1:0] : wd_q[DW-1:BW]);
  assign ext_dout = (word_q && wide_a) ? wd_q : {wbyte, wbyte};

  for (genvar g = 0; g < NAREA; g++) begin : g_cs
    assign ext_cs_n[g] = !(run && cur_area == AREA_W'(g));
  end
endmodule

module ext_area_bus_ctl_chk #(
  parameter int NAREA = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_start,
  input logic             busy,
  input logic             rdy,
  input logic [NAREA-1:0] ext_cs_n,
  input logic             ext_rd_n,
  input logic             ext_wr_n
);
  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n));
  assert_cs_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || rdy) |-> (ext_cs_n == '1));
  assert_strobe_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> (ext_cs_n != '1));
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n));
  assert_rdy_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> busy);
  assert_rdy_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> (!rdy && !busy));
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start) |=> busy);
  assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdy) |=> busy);
endmodule

bind ext_area_bus_ctl ext_area_bus_ctl_chk #(.NAREA(NAREA)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start), .busy(busy), .rdy(rdy),
  .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n)
);

// File: tb/ext_area_bus_ctl_bench.sv
module ext_area_bus_ctl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_wide = 0, cfg_three = 0;
  logic [2:0] cfg_area = 0;
  logic [1:0] cfg_wait = 0;
  logic req_start = 0, req_write = 0, req_word = 0;
  logic [23:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic busy, rdy, ext_rd_n, ext_wr_n;
  logic [15:0] rdata, ext_dout, ext_din;
  logic [23:0] ext_addr;
  logic [7:0] ext_cs_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ a[7:0] ^ 8'h3C};
  endfunction
  assign ext_din = mem(ext_addr);

  ext_area_bus_ctl u_ext_area_bus_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area),
    .cfg_wide(cfg_wide), .cfg_three(cfg_three), .cfg_wait(cfg_wait),
    .req_start(req_start), .req_addr(req_addr), .req_write(req_write),
    .req_word(req_word), .req_wdata(req_wdata), .busy(busy), .rdy(rdy),
    .rdata(rdata), .ext_addr(ext_addr), .ext_cs_n(ext_cs_n),
    .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_dout(ext_dout),
    .ext_din(ext_din));

  typedef struct {
    logic busy, rdy, rd_n, wr_n, three, chk_rd;
    logic [7:0] cs_n;
    logic [23:0] addr;
    logic [15:0] dout, rdata;
    string tag;
  } ent_t;

  ent_t q[$];
  logic m_wide [8];
  logic m_three [8];
  int   m_wait [8];
  logic cur_busy = 0;
  string cur_tag = "reset";
  int checks = 0, fails = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] %s act=%h exp=%h t=%0t", req, cur_tag, what, act, exp, $time);
    end
  endtask

  // reference model: accept and configuration on rising edges
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_wide[i] = 1; m_three[i] = 1; m_wait[i] = 3; end
    end else begin
      if (!cur_busy && req_start) begin
        int ar, len, n;
        logic w;
        ent_t e;
        ar  = req_addr[23:21];
        w   = m_wide[ar];
        len = m_three[ar] ? 3 + m_wait[ar] : 2;
        n   = (req_word && !w) ? 2 : 1;
        for (int h = 0; h < n; h++) begin
          for (int s = 0; s < len; s++) begin
            logic stb;
            e = '{default: '0};
            e.tag = cur_tag;
            e.busy = 1; e.rdy = 0; e.three = m_three[ar];
            e.cs_n = ~(8'd1 << ar);
            stb = m_three[ar] ? (s >= 1) : 1'b1;
            e.rd_n = !(stb && !req_write);
            e.wr_n = !(stb && req_write);
            if (req_word) e.addr = w ? {req_addr[23:1], 1'b0} : {req_addr[23:1], h[0]};
            else          e.addr = req_addr;
            if (req_word && w) e.dout = req_wdata;
            else if (req_word) e.dout = (h == 0) ? {2{req_wdata[15:8]}} : {2{req_wdata[7:0]}};
            else e.dout = {2{req_wdata[7:0]}};
            q.push_back(e);
          end
        end
        e = '{default: '0};
        e.tag = cur_tag;
        e.busy = 1; e.rdy = 1; e.cs_n = 8'hFF; e.rd_n = 1; e.wr_n = 1;
        e.chk_rd = !req_write;
        if (req_word && w) e.rdata = mem({req_addr[23:1], 1'b0});
        else if (req_word) e.rdata = {mem({req_addr[23:1], 1'b0}) >> 0 & 16'h00FF,
                                      8'h00} | {8'h00, mem({req_addr[23:1], 1'b1}) & 16'h00FF};
        else if (w && !req_addr[0]) e.rdata = {8'h00, mem(req_addr) >> 8};
        else e.rdata = {8'h00, mem(req_addr) & 16'h00FF};
        q.push_back(e);
      end
      if (cfg_we) begin
        m_wide[cfg_area] = cfg_wide; m_three[cfg_area] = cfg_three; m_wait[cfg_area] = cfg_wait;
      end
    end
  end

  // comparison on falling edges, every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      ent_t e;
      if (q.size() > 0) begin e = q.pop_front(); cur_busy = 1; end
      else begin
        e = '{default: '0};
        e.cs_n = 8'hFF; e.rd_n = 1; e.wr_n = 1; e.tag = cur_tag;
        cur_busy = 0;
      end
      chk("R10", "busy", busy, e.busy);
      chk("R10", "rdy", rdy, e.rdy);
      chk("R1", "cs_n", ext_cs_n, e.cs_n);
      chk(e.three ? "R5" : "R4", "rd_n/wr_n", {ext_rd_n, ext_wr_n}, {e.rd_n, e.wr_n});
      if (e.cs_n != 8'hFF) chk("R7", "ext_addr", ext_addr, e.addr);
      if (!e.wr_n) chk("R9", "ext_dout", ext_dout, e.dout);
      if (e.rdy && e.chk_rd) chk("R8", "rdata", rdata, e.rdata);
    end
  end

  task automatic cfg(input int area, input logic wide, input logic three, input int wt);
    @(negedge clk);
    cfg_we = 1; cfg_area = area[2:0]; cfg_wide = wide; cfg_three = three; cfg_wait = wt[1:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic start(input logic [23:0] a, input logic wr, input logic wd,
                       input logic [15:0] d, input int hold);
    @(negedge clk);
    req_start = 1; req_addr = a; req_write = wr; req_word = wd; req_wdata = d;
    repeat (hold) @(negedge clk);
    req_start = 0;
  endtask

  task automatic settle();
    do @(negedge clk); while (busy || q.size() > 0);
    @(negedge clk);
  endtask

  task automatic acc(input logic [23:0] a, input logic wr, input logic wd, input logic [15:0] d);
    start(a, wr, wd, d, 1);
    settle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R2 reset config";
    acc({3'd0, 21'h000100}, 0, 1, 0);
    acc({3'd6, 21'h000033}, 0, 0, 0);

    cur_tag = "R3 R6 8-bit 2-state wait ignored";
    cfg(1, 0, 0, 3);
    acc({3'd1, 21'h000202}, 0, 1, 0);
    acc({3'd1, 21'h000205}, 0, 0, 0);
    acc({3'd1, 21'h000208}, 1, 1, 16'hBEEF);

    cur_tag = "R4 R8 R9 16-bit 2-state byte lanes";
    cfg(2, 1, 0, 0);
    acc({3'd2, 21'h000410}, 0, 0, 0);
    acc({3'd2, 21'h000411}, 0, 0, 0);
    acc({3'd2, 21'h000413}, 1, 0, 16'h12C7);
    acc({3'd2, 21'h000415}, 0, 1, 0);

    cur_tag = "R5 R7 8-bit 3-state wait 2";
    cfg(3, 0, 1, 2);
    acc({3'd3, 21'h000600}, 1, 1, 16'hA15E);
    acc({3'd3, 21'h000607}, 0, 1, 0);

    cur_tag = "R5 3-state wait 0 and 1";
    cfg(5, 1, 1, 0);
    cfg(7, 1, 1, 1);
    acc({3'd5, 21'h000800}, 1, 1, 16'h5AA5);
    acc({3'd7, 21'h000901}, 0, 0, 0);

    cur_tag = "R10 held start ignored while busy";
    start({3'd4, 21'h000A00}, 0, 1, 0, 12);
    settle();

    cur_tag = "R11 config change mid-access";
    start({3'd3, 21'h000C00}, 0, 1, 0, 1);
    cfg(3, 1, 0, 0);
    settle();
    acc({3'd3, 21'h000C00}, 0, 1, 0);

    cur_tag = "R11 back-to-back areas";
    start({3'd1, 21'h000E01}, 0, 1, 0, 1);
    do @(negedge clk); while (!rdy);
    req_start = 1; req_addr = {3'd2, 21'h000E02}; req_write = 0; req_word = 1;
    @(negedge clk);
    req_start = 0;
    settle();

    cur_tag = "R1 all areas";
    for (int i = 0; i < 8; i++) acc({i[2:0], 21'h001000 + 21'(i)}, 0, 0, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule